// File: doc/BRIEF.md
# Folded single-port static memory array

This block is a synthesizable model of a single-port memory holding 2^N words of 2^M bits. The words are not stored one per row. The array is folded by a factor 2^K, so it has 2^(N-K) rows, and each row is 2^(M+K) columns wide. Each row therefore holds 2^K words side by side.

A word address is split into two parts:
- The upper N-K bits select a row. They pass through a predecoded row decoder, in which every pair of address bits makes a one-hot group of four lines. Each wordline is the AND of one line from each group.
- The lower K bits select a column. They drive one 2^K:1 multiplexer for each data bit, which picks the addressed word out of the wide row.

On a write, the block updates only the columns of the addressed word. The other words in the same row keep their contents. Read data is registered.

The parameters must satisfy 0 <= K <= N, and N-K must be even so the row address splits cleanly into 2-bit groups. The wordline and column-select vectors are brought out so that a checker can observe the decode.

Top module: `fsram_folded`

## Requirements
- R1: While reset is held, and after it is released, `rdata` is all zero and every `wordline` bit is zero as long as `acc_en` is low.
- R2: A read (`acc_en`=1, `wr_en`=0) returns the data most recently written to that address.
- R3: Read data is registered. `rdata` changes at the first rising clock edge after the read is presented, and not before that edge.
- R4: A write changes only the addressed word. The other words that share its row, and all other rows, keep their contents.
- R5: During a write cycle, `rdata` keeps its previous value.
- R6: During an idle cycle (`acc_en`=0), `rdata` keeps its value and no wordline is raised.
- R7: During an access, exactly one bit of `wordline` is high. Its index equals `addr[N-1:K]`, the upper address bits. With the default parameters (N=5, K=1) this is `addr>>1`.
- R8: `col_sel` is always one-hot. Its set bit index equals `addr[K-1:0]`, which with the defaults is `addr & 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access request for this cycle |
| wr_en | input | 1 | 1 = write, 0 = read (used only when `acc_en` is high) |
| addr | input | N | Word address |
| wdata | input | 2^M | Write data |
| rdata | output | 2^M | Registered read data |
| wordline | output | 2^(N-K) | Row select lines, one per row |
| col_sel | output | 2^K | One-hot column select |

## Verification
The bench has two targeted tests, plus a long pseudo-random mix of reads, writes and idles checked against a behavioural word-indexed model.

The first targeted test writes one word and then reads back its row neighbour. A write that is not masked to the addressed columns would overwrite that neighbour. A multiplexer that swaps the column order would return the neighbour's data in its place.

The second targeted test places reads between writes and idles, and samples `rdata` both before and after each edge. An output register that loads on writes or idles, or that is not registered at all, shows a changed value where the held value is expected.

The wordline and column-select checks on every cycle catch a predecode group wired to the wrong address pair, and any decode that drops or merges rows.

// File: rtl/fsram_pkg.sv
// Package: shared helpers for the folded memory.
// Assumes: callers pass 2-bit fields to the predecode function.
package fsram_pkg;

    // Turns a 2-bit field into a 1-of-4 hot group.
    function automatic logic [3:0] pre_dec4(input logic [1:0] f);
        logic [3:0] h;
        h = 4'b0000;
        h[f] = 1'b1;
        return h;
    endfunction

endpackage

// File: rtl/fsram_row_dec.sv
// Module: predecoded row decoder.
// Each address pair forms a one-hot group of four lines; each wordline is
// the AND of one line per group and the access enable.
// Assumes: RA_BITS is even (0 allowed, giving a single always-selected row).
module fsram_row_dec #(
    parameter int RA_BITS = 4,
    localparam int ROWS   = 1 << RA_BITS,
    localparam int RA_W   = (RA_BITS > 0) ? RA_BITS : 1,
    localparam int GROUPS = RA_BITS / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [RA_W-1:0] row_addr,
    output logic [ROWS-1:0] wordline
);
    import fsram_pkg::*;

    generate
        if (RA_BITS == 0) begin : g_single_row
            // One row only: it is selected on any access.
            assign wordline = en;
        end else begin : g_predecoded
            logic [3:0] pre [GROUPS];

            for (genvar g = 0; g < GROUPS; g++) begin : g_grp
                // One predecoder per address pair.
                assign pre[g] = pre_dec4(row_addr[2*g+1:2*g]);

                // Each group must have exactly one hot line.
                p_group_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
                    $countones(pre[g]) == 1);
            end

            // Final AND stage: one line from each group, gated by enable.
            always_comb begin
                for (int r = 0; r < ROWS; r++) begin
                    wordline[r] = en;
                    for (int g = 0; g < GROUPS; g++) begin
                        wordline[r] = wordline[r] & pre[g][(r >> (2*g)) & 3];
                    end
                end
            end
        end
    endgenerate

    // R7: exactly one row during an access.
    p_one_wordline_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> $countones(wordline) == 1);
    // R6: no row on an idle cycle.
    p_idle_no_wordline_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> wordline == '0);

endmodule

// File: rtl/fsram_col_mux.sv
// Module: column decoder and per-bit column multiplexers.
// Bit b of the word in column slot c sits at wide column b*FOLD + c, so
// each data bit owns FOLD adjacent columns feeding one FOLD:1 multiplexer.
// Assumes: CA_BITS may be 0 (no folding, direct wiring).
module fsram_col_mux #(
    parameter int CA_BITS = 1,
    parameter int DATA_W  = 4,
    localparam int FOLD   = 1 << CA_BITS,
    localparam int COLS   = DATA_W * FOLD,
    localparam int CA_W   = (CA_BITS > 0) ? CA_BITS : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CA_W-1:0]   col_addr,
    input  logic [COLS-1:0]   row_bits,
    output logic [FOLD-1:0]   col_sel,
    output logic [DATA_W-1:0] rd_word
);
    generate
        if (CA_BITS == 0) begin : g_unfolded
            // No folding: a single column slot, wired straight through.
            assign col_sel = 1'b1;
            assign rd_word = row_bits;
        end else begin : g_folded
            // Column decoder: one-hot slot select.
            always_comb begin
                col_sel = '0;
                col_sel[col_addr] = 1'b1;
            end

            for (genvar b = 0; b < DATA_W; b++) begin : g_bit
                // FOLD:1 multiplexer for data bit b.
                assign rd_word[b] = row_bits[b*FOLD + int'(col_addr)];
            end
        end
    endgenerate

    // R8: the column select is always one-hot.
    p_colsel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_sel) == 1);

endmodule

// File: rtl/fsram_array.sv
// Module: cell storage, ROWS x COLS bits.
// Writes land only in the columns of the selected slot of the raised row.
// The read path is a wired-OR of all rows gated by their wordlines.
// Assumes: at most one wordline high; cells are not reset, as in a real array.
module fsram_array #(
    parameter int ROWS   = 16,
    parameter int FOLD   = 2,
    parameter int DATA_W = 4,
    localparam int COLS  = DATA_W * FOLD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROWS-1:0]   wordline,
    input  logic              wr_en,
    input  logic [FOLD-1:0]   col_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [COLS-1:0]   row_bits
);
    logic [COLS-1:0] cells [ROWS];

    // Column write drivers: a cell is written only under its wordline and slot.
    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (wordline[r] && wr_en) begin
                for (int c = 0; c < COLS; c++) begin
                    if (col_sel[c % FOLD]) begin
                        cells[r][c] <= wdata[c / FOLD];
                    end
                end
            end
        end
    end

    // Read path: OR of every row gated by its wordline.
    always_comb begin
        row_bits = '0;
        for (int r = 0; r < ROWS; r++) begin
            row_bits = row_bits | (cells[r] & {COLS{wordline[r]}});
        end
    end

    // A write always arrives with at most one row raised (R7).
    p_write_single_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $countones(wordline) <= 1);

endmodule

// File: rtl/fsram_folded.sv
// Module: top of the folded single-port memory.
// Splits the address into a row part (upper N-K bits) and a column part
// (lower K bits), raises one wordline per access and registers read data.
// Assumes: 0 <= K <= N and N-K even.
module fsram_folded #(
    parameter int N = 5,
    parameter int M = 2,
    parameter int K = 1,
    localparam int DATA_W  = 1 << M,
    localparam int RA_BITS = N - K,
    localparam int ROWS    = 1 << RA_BITS,
    localparam int FOLD    = 1 << K,
    localparam int COLS    = DATA_W * FOLD,
    localparam int RA_W    = (RA_BITS > 0) ? RA_BITS : 1,
    localparam int CA_W    = (K > 0) ? K : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              wr_en,
    input  logic [N-1:0]      addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [ROWS-1:0]   wordline,
    output logic [FOLD-1:0]   col_sel
);
    logic [RA_W-1:0]   row_addr;
    logic [CA_W-1:0]   col_addr;
    logic [COLS-1:0]   row_bits;
    logic [DATA_W-1:0] rd_word;

    // Parameter legality check at time zero.
    initial begin
        p_param_legal: assert (K >= 0 && K <= N && (RA_BITS % 2) == 0)
            else $error("fsram_folded: illegal N/K combination");
    end

    generate
        if (RA_BITS == 0) begin : g_no_row_bits
            assign row_addr = '0;
        end else begin : g_row_bits
            assign row_addr = addr[N-1:K];
        end
        if (K == 0) begin : g_no_col_bits
            assign col_addr = '0;
        end else begin : g_col_bits
            assign col_addr = addr[CA_W-1:0];
        end
    endgenerate

    fsram_row_dec #(.RA_BITS(RA_BITS)) u_row_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (acc_en),
        .row_addr (row_addr),
        .wordline (wordline)
    );

    fsram_col_mux #(.CA_BITS(K), .DATA_W(DATA_W)) u_col_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_addr (col_addr),
        .row_bits (row_bits),
        .col_sel  (col_sel),
        .rd_word  (rd_word)
    );

    fsram_array #(.ROWS(ROWS), .FOLD(FOLD), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wordline (wordline),
        .wr_en    (wr_en),
        .col_sel  (col_sel),
        .wdata    (wdata),
        .row_bits (row_bits)
    );

    // Output register: loads only on a read access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (acc_en && !wr_en) begin
            rdata <= rd_word;
        end
    end

    // R7: the raised row matches the upper address bits.
    p_row_matches_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> wordline[row_addr]);
    // R8: the selected slot matches the lower address bits.
    p_col_matches_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        col_sel[col_addr]);
    // R5: read data holds across a write.
    p_hold_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && wr_en) |=> $stable(rdata));
    // R6: read data holds across an idle cycle.
    p_hold_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(rdata));

endmodule

// File: tb/fsram_folded_tb.sv
module fsram_folded_tb;
    localparam int N = 5;
    localparam int M = 2;
    localparam int K = 1;
    localparam int DW = 1 << M;
    localparam int WORDS = 1 << N;
    localparam int ROWS = 1 << (N - K);
    localparam int FOLD = 1 << K;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_en = 1'b0;
    logic wr_en = 1'b0;
    logic [N-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [ROWS-1:0] wordline;
    logic [FOLD-1:0] col_sel;

    int checks = 0;
    int failures = 0;
    int model [WORDS];
    int exp_rd = 0;
    int lcg = 12345;
    bit done = 0;

    always #10 clk = ~clk;

    fsram_folded #(.N(N), .M(M), .K(K)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .wordline(wordline), .col_sel(col_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the decode and the
    // unchanged output, then check the registered output after the edge.
    task automatic op(input bit e, input bit w, input int a, input int d, input string rd_tag);
        int exp_wl;
        @(negedge clk);
        acc_en = e; wr_en = w; addr = a[N-1:0]; wdata = d[DW-1:0];
        #2;
        exp_wl = e ? (1 << (a >> K)) : 0;
        check(e ? "R7 wordline" : "R6 wordline idle", int'(wordline), exp_wl);
        check("R8 col_sel", int'(col_sel), 1 << (a % FOLD));
        check("R3 rdata before edge", int'(rdata), exp_rd);
        @(posedge clk);
        if (e && w) model[a] = d & ((1 << DW) - 1);
        if (e && !w) exp_rd = model[a];
        #2;
        check(!e ? "R6 hold idle" : (w ? "R5 hold write" : rd_tag), int'(rdata), exp_rd);
    endtask

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        #2;
        check("R1 rdata reset", int'(rdata), 0);
        check("R1 wordline reset", int'(wordline), 0);
        @(negedge clk);
        rst_n = 1'b1;
        op(0, 0, 0, 0, "R1");
        check("R1 rdata after reset", int'(rdata), 0);

        // Fill every word.
        for (int a = 0; a < WORDS; a++) op(1, 1, a, (a * 7 + 3), "R2");
        // R2: read back in a scattered order.
        for (int i = 0; i < WORDS; i++) op(1, 0, (i * 13) % WORDS, 0, "R2 readback");

        // R4: row neighbours stay intact after a write to one of them.
        op(1, 1, 6, 4'hA, "R4");
        op(1, 1, 7, 4'h5, "R4");
        op(1, 1, 6, 4'h3, "R4");
        op(1, 0, 7, 0, "R4 neighbour kept");
        op(1, 0, 6, 0, "R4 word updated");
        op(1, 0, 8, 0, "R4 other row kept");

        // R3/R5/R6: reads interleaved with writes and idles.
        op(1, 0, 31, 0, "R3 read");
        op(1, 1, 31, 4'hF, "R5");
        op(0, 0, 2, 0, "R6");
        op(1, 0, 31, 0, "R3 read after write");
        op(0, 1, 0, 4'h9, "R6");
        op(1, 0, 0, 0, "R6 idle write ignored");

        // Pseudo-random mix checked against the model.
        for (int i = 0; i < 400; i++) begin
            int sel;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            sel = (lcg >> 8) % 4;
            op(sel != 0, sel == 1, (lcg >> 12) % WORDS, (lcg >> 20), "R2 mixed read");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule